// File: doc/BRIEF.md
# Lookahead Critical-Queue Head Cache Controller

This controller fronts a slow bulk memory that holds many per-queue cell FIFOs. An arbiter issues one request per cell slot, a valid bit and a queue id. The controller holds each request in a lookahead line and delivers the requested cell a fixed number of slots later. Meanwhile it keeps the head cells of every queue in a small on-chip store, so the slow memory never sits on the dispatch path.

Once every B slots the controller makes a refill decision. It walks the lookahead from the oldest request to the newest and counts demand per queue. The first queue whose demand overtakes its committed supply is chosen, and a read command for B cells of that queue goes to bulk memory. The committed supply is cells cached plus cells already ordered. The bulk memory answers after its own fixed latency with all B cells in one wide beat, and the controller appends them to that queue's head store. A refill is never chosen round-robin or by lowest occupancy. If no queue would fall short, no command is issued.

With Q queues the lookahead is Q(B-1)+1 slots deep. A dispatch that finds no cached cell for its queue raises a sticky error flag and leaves that queue's store untouched.

Top module: `head_cache_ctrl`

## Requirements
- R1: While rst_n is low, and after reset, refill_valid, out_valid, out_data and err_underflow are all zero.
- R2: A request sampled with req_valid high at clock edge n appears on out_valid/out_qid after edge n+LA, where LA = NQ*(B-1)+1 (13 at defaults). A slot with req_valid low produces out_valid low LA edges later.
- R3: Refill decisions happen only at edges where the count of edges since reset release is a multiple of B. refill_valid is never high after any other edge, and so never on two adjacent cycles.
- R4: At a decision edge, the lookahead holds the requests from the previous LA edges. Each queue's committed supply is B times its issued refills minus its dispatched requests. Scanning from the oldest request, refill_qid is the queue of the first request whose running count for its own queue exceeds that supply.
- R5: When no request in the lookahead exceeds its queue's committed supply, no refill is issued at that decision edge.
- R6: The committed supply of any queue never exceeds LA-1+B cells, which bounds each queue's head store.
- R7: fill_data carries B cells of DW bits, with cell j at bits [j*DW +: DW], and adds B cells to queue fill_qid. Successful dispatches of a queue return its cells in arrival order, lowest cell of each beat first.
- R8: A dispatch at an edge where its queue held zero cells before that edge sets err_underflow. A fill arriving on the same edge does not count. The flag stays high until reset, and the failed dispatch consumes no cell.
- R9: In a slot without a dispatched request, and in a dispatch that underflows, out_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell-slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Arbiter request present in this slot |
| req_qid | input | QW | Queue id of the request |
| refill_valid | output | 1 | Read command to bulk memory for B cells |
| refill_qid | output | QW | Queue to read from bulk memory |
| fill_valid | input | 1 | Bulk memory returns a refill beat |
| fill_qid | input | QW | Queue of the returned beat |
| fill_data | input | B*DW | B returned cells, cell j at bits [j*DW +: DW] |
| out_valid | output | 1 | Requested cell dispatched this slot |
| out_qid | output | QW | Queue of the dispatched cell |
| out_data | output | DW | Dispatched cell |
| err_underflow | output | 1 | Sticky: a dispatch found its queue empty |

## Verification
The bench builds the block with four queues, B=4 and 8-bit cells, so the lookahead is 13 slots and the shared budget is 12 cells. The bulk-memory stub answers three cycles after each command. At this size a burst cycling through all four queues from an empty cache reaches a shortfall within 16 slots, which exercises the sticky error. A long single-queue stream pushes one queue's committed supply to its ceiling. Random segments at low, medium and bursty load check every decision edge against an independent scan of the bench's own request history, and they check every dispatched cell against the sequence numbers the stub put into it.

// File: rtl/head_cache_ctrl.sv
module head_cache_ctrl #(
  parameter int NQ = 4,
  parameter int B  = 4,
  parameter int DW = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [QW-1:0]   req_qid,
  output logic            refill_valid,
  output logic [QW-1:0]   refill_qid,
  input  logic            fill_valid,
  input  logic [QW-1:0]   fill_qid,
  input  logic [B*DW-1:0] fill_data,
  output logic            out_valid,
  output logic [QW-1:0]   out_qid,
  output logic [DW-1:0]   out_data,
  output logic            err_underflow
);
  localparam int LA       = NQ * (B - 1) + 1;
  localparam int CRED_MAX = LA - 1 + B;
  localparam int PW       = $clog2(CRED_MAX);
  localparam int DEPTH    = 1 << PW;
  localparam int OW       = $clog2(DEPTH + 1);
  localparam int CW       = $clog2(CRED_MAX + 1) + 2;
  localparam int PHW      = (B > 1) ? $clog2(B) : 1;

  logic [PHW-1:0]        phase;
  logic                  la_v [LA];
  logic [QW-1:0]         la_q [LA];
  logic signed [CW-1:0]  cred [NQ];
  logic [OW-1:0]         occ  [NQ];
  logic [PW-1:0]         wp   [NQ];
  logic [PW-1:0]         rp   [NQ];
  logic [DW-1:0]         mem  [NQ][DEPTH];
  int                    need [NQ];
  logic                  crit_hit;
  logic [QW-1:0]         crit_q;

  wire          decide  = (phase == '0);
  wire          disp_v  = la_v[LA-1];
  wire [QW-1:0] disp_q  = la_q[LA-1];
  wire          disp_ok = disp_v && (occ[disp_q] != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else if (int'(phase) == B - 1) phase <= '0;
    else phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LA; i++) begin
        la_v[i] <= 1'b0;
        la_q[i] <= '0;
      end
    end else begin
      la_v[0] <= req_valid;
      la_q[0] <= req_qid;
      for (int i = 1; i < LA; i++) begin
        la_v[i] <= la_v[i-1];
        la_q[i] <= la_q[i-1];
      end
    end
  end

  always_comb begin
    crit_hit = 1'b0;
    crit_q   = '0;
    for (int q = 0; q < NQ; q++) need[q] = 0;
    for (int i = LA - 1; i >= 0; i--) begin
      if (la_v[i] && !crit_hit) begin
        need[la_q[i]] = need[la_q[i]] + 1;
        if (need[la_q[i]] > int'(cred[la_q[i]])) begin
          crit_hit = 1'b1;
          crit_q   = la_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refill_valid <= 1'b0;
      refill_qid   <= '0;
    end else begin
      refill_valid <= decide && crit_hit;
      refill_qid   <= (decide && crit_hit) ? crit_q : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) cred[q] <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        cred[q] <= cred[q]
                 + ((decide && crit_hit && int'(crit_q) == q) ? $signed(CW'(B)) : $signed(CW'(0)))
                 - ((disp_v && int'(disp_q) == q) ? $signed(CW'(1)) : $signed(CW'(0)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        occ[q] <= '0;
        wp[q]  <= '0;
        rp[q]  <= '0;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        occ[q] <= occ[q]
                + ((fill_valid && int'(fill_qid) == q) ? OW'(B) : OW'(0))
                - ((disp_ok && int'(disp_q) == q) ? OW'(1) : OW'(0));
        if (fill_valid && int'(fill_qid) == q) wp[q] <= wp[q] + PW'(B);
        if (disp_ok && int'(disp_q) == q) rp[q] <= rp[q] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      for (int j = 0; j < B; j++)
        mem[fill_qid][wp[fill_qid] + PW'(j)] <= fill_data[j*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_qid       <= '0;
      out_data      <= '0;
      err_underflow <= 1'b0;
    end else begin
      out_valid     <= disp_v;
      out_qid       <= disp_v ? disp_q : '0;
      out_data      <= disp_ok ? mem[disp_q][rp[disp_q]] : '0;
      err_underflow <= err_underflow | (disp_v && occ[disp_q] == '0);
    end
  end

  a_r3_decision_phase: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |-> $past(phase) == '0);

  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |=> !refill_valid);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);

  a_r7_fill_room: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> int'(occ[fill_qid]) <= DEPTH - B);

  a_r9_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == '0);

  always @(posedge clk) begin
    if (rst_n) begin
      for (int q = 0; q < NQ; q++)
        a_r6_credit_cap: assert (int'(cred[q]) <= CRED_MAX);
    end
  end
endmodule

// File: tb/test_head_cache_ctrl.sv
module test_head_cache_ctrl;
  localparam int NQ   = 4;
  localparam int B    = 4;
  localparam int DW   = 8;
  localparam int QW   = 2;
  localparam int LA   = NQ * (B - 1) + 1;
  localparam int L    = 3;
  localparam int HMAX = 8192;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [QW-1:0]   req_qid = '0;
  logic            refill_valid;
  logic [QW-1:0]   refill_qid;
  logic            fill_valid = 1'b0;
  logic [QW-1:0]   fill_qid = '0;
  logic [B*DW-1:0] fill_data = '0;
  logic            out_valid;
  logic [QW-1:0]   out_qid;
  logic [DW-1:0]   out_data;
  logic            err_underflow;

  head_cache_ctrl #(.NQ(NQ), .B(B), .DW(DW)) i_head_cache_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_qid(req_qid),
    .refill_valid(refill_valid), .refill_qid(refill_qid),
    .fill_valid(fill_valid), .fill_qid(fill_qid), .fill_data(fill_data),
    .out_valid(out_valid), .out_qid(out_qid), .out_data(out_data),
    .err_underflow(err_underflow)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  int ecount;
  bit hv [HMAX];
  int hq [HMAX];
  int bcred [NQ], bocc [NQ], dcount [NQ], fcount [NQ];
  bit berr, fpend;
  int fdue, fq;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, expv, ecount);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; fill_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(refill_valid == 1'b0, "R1 refill_valid", refill_valid, 0);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(out_data == '0, "R1 out_data", out_data, 0);
    check(err_underflow == 1'b0, "R1 err_underflow", err_underflow, 0);
    for (int q = 0; q < NQ; q++) begin
      bcred[q] = 0; bocc[q] = 0; dcount[q] = 0; fcount[q] = 0;
    end
    ecount = 0; berr = 0; fpend = 0;
    rst_n = 1'b1;
  endtask

  task automatic step(input bit v, input int q);
    bit exp_rv, fdrv, dv;
    int exp_rq, fdq, idx, dq, e;
    int need [NQ];
    req_valid = v; req_qid = QW'(q);
    hv[ecount] = v; hq[ecount] = q;
    fdrv = fpend && (fdue == ecount);
    fdq = fq;
    fill_valid = fdrv;
    fill_qid = QW'(fq);
    for (int j = 0; j < B; j++)
      fill_data[j*DW +: DW] = {QW'(fq), (DW-QW)'(fcount[fq] * B + j)};
    exp_rv = 0; exp_rq = 0;
    if (ecount % B == 0) begin
      for (int k = 0; k < NQ; k++) need[k] = 0;
      for (int k = ecount - LA; k < ecount; k++) begin
        if (k >= 0 && hv[k] && !exp_rv) begin
          need[hq[k]]++;
          if (need[hq[k]] > bcred[hq[k]]) begin exp_rv = 1; exp_rq = hq[k]; end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    e = ecount;
    if (e % B != 0)
      check(refill_valid == 1'b0, "R3 refill off-phase", refill_valid, 0);
    else if (exp_rv) begin
      check(refill_valid == 1'b1, "R4 refill issued", refill_valid, 1);
      check(int'(refill_qid) == exp_rq, "R4 critical queue", refill_qid, exp_rq);
    end else
      check(refill_valid == 1'b0, "R5 no shortfall no refill", refill_valid, 0);
    if (exp_rv) bcred[exp_rq] += B;
    idx = e - LA;
    dv = (idx >= 0) && hv[idx];
    check(out_valid == dv, "R2 dispatch delay", out_valid, dv);
    if (dv) begin
      dq = hq[idx];
      check(int'(out_qid) == dq, "R2 dispatch queue", out_qid, dq);
      bcred[dq]--;
      check(bcred[dq] <= LA - 1 + B, "R6 credit cap", bcred[dq], LA - 1 + B);
      if (bocc[dq] == 0) begin
        berr = 1;
        check(out_data == '0, "R9 underflow data", out_data, 0);
      end else begin
        bocc[dq]--;
        check(int'(out_data) == int'({QW'(dq), (DW-QW)'(dcount[dq])}), "R7 cell order",
              out_data, int'({QW'(dq), (DW-QW)'(dcount[dq])}));
        dcount[dq]++;
      end
    end else
      check(out_data == '0, "R9 idle data", out_data, 0);
    if (fdrv) begin
      bocc[fdq] += B;
      fcount[fdq]++;
      fpend = 0;
      fill_valid = 1'b0;
    end
    if (refill_valid) begin
      fpend = 1; fdue = e + L; fq = int'(refill_qid);
    end
    check(err_underflow == berr, "R8 sticky underflow", err_underflow, berr);
    ecount++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", tests, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cur;
    void'($urandom(32'd1357));
    do_reset();
    // R5: idle traffic gives no refill; then a lone request gets one
    repeat (12) step(0, 0);
    step(1, 2);
    repeat (24) step(0, 0);
    check(err_underflow == 1'b0, "R4 lone request served", err_underflow, 0);
    // R8: cold-start rotation across all queues runs short at edge 16
    do_reset();
    for (int n = 0; n < 16; n++) step(1, n % NQ);
    repeat (20) step(0, 0);
    check(err_underflow == 1'b1, "R8 cold-start shortfall", err_underflow, 1);
    do_reset();
    check(err_underflow == 1'b0, "R1 reset clears flag", err_underflow, 0);
    // R6: single-queue stream
    repeat (300) step(1, 1);
    repeat (20) step(0, 0);
    // random low load
    do_reset();
    repeat (2000) step(($urandom % 4) == 0, $urandom % NQ);
    // random medium load
    do_reset();
    repeat (2000) step($urandom % 2, $urandom % NQ);
    // random bursts on one queue at a time
    do_reset();
    cur = 0;
    for (int n = 0; n < 2000; n++) begin
      if ($urandom % 16 == 0) cur = $urandom % NQ;
      step(($urandom % 8) != 0, cur);
    end
    repeat (20) step(0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule